// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller Core

This block collects eight interrupt request lines and decides which one is presented to the processor. Each line can be set to edge or level sensing. The controller keeps a pending-request register, an in-service register, a mask register and a rotating priority base. When an unmasked request outranks everything currently in service, it raises `intReq` and forms a vector from a programmable base and the winning line number. The processor then confirms the line on the acknowledge input.

Software programs the core through a byte-wide, two-address port. A write to address 0 with bit 4 set starts a configuration sequence of up to three more bytes on address 1. The first of these bytes carries the vector base. The second is a placeholder. The third, when requested, selects auto-EOI and nested handling. After configuration, address-1 writes load the mask. Address-0 writes either issue an end-of-interrupt or rotation command (selected by bits 7:5), or act as a control word (bit 3 set) that chooses the readback register, arms a poll, or toggles special masking. A poll read returns the winning line and retires it, so the controller can be serviced without the acknowledge path.

Top module: `pic_core`

## Requirements
- R1: After reset the pending, in-service and mask registers read as zero on their ports, `intReq` is low and the priority base is line 0.
- R2: An edge-sensed line (levelSel bit 0) sets its pending bit only on a low-to-high change of `irqIn`. A line held high after its bit was cleared does not set it again until it drops and rises.
- R3: A level-sensed line (levelSel bit 1) has a pending bit that equals its input one cycle later. Acknowledge does not clear it.
- R4: An address-0 write with bit 4 set clears the pending, in-service, mask, edge history, priority base and all mode flags, and starts configuration. Bit 0 of that byte says whether a third byte follows. Address-1 bytes are consumed as configuration words and do not reach the mask. `intReq` stays low until configuration ends.
- R5: Outside configuration, an address-1 write loads the mask and an address-1 read returns it. A masked line never drives `intReq`.
- R6: Rank is (line − base) mod 8, and the lowest rank wins. A request is presented only if it ranks strictly above every in-service line.
- R7: A normal acknowledge sets the in-service bit of `ackLine` and clears its pending bit when the line is edge-sensed.
- R8: With auto-EOI (bit 1 of the last configuration byte), an acknowledge leaves the in-service bits unchanged. If rotate-on-auto-EOI was armed by command 4 (disarmed by command 0), it also moves the base to line + 1.
- R9: Command 1 clears the highest-ranked in-service bit. Command 5 does the same and moves the base to that line + 1.
- R10: Command 3 clears in-service bit (data & 7). Command 7 does the same and moves the base to that line + 1. Command 6 sets the base to ((data & 7) + 1) mod 8. Command 2 changes nothing.
- R11: A control word with bit 1 set selects the address-0 readback: bit 0 = 1 for in-service, 0 for pending. The reset choice is pending.
- R12: A control word with bit 2 arms a poll. The next read returns the winning line number, clears its pending and in-service bits, and disarms the poll. If nothing qualifies, that read returns 0x07.
- R13: With special masking on (control word bit 6 set, value from bit 5), masked in-service lines do not block lower ranks. With nested mode (bit 4 of the last configuration byte), the cascade line's in-service bit does not block itself.
- R14: `intVector` equals the configured base byte with its low three bits cleared, ORed with the winning line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| rdEn | input | 1 | Byte read strobe (consumes a poll) |
| addr | input | 1 | Register address, 0 or 1 |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, combinational from address and state |
| irqIn | input | 8 | Interrupt request lines |
| levelSel | input | 8 | Per-line sensing: 1 level, 0 edge |
| ackValid | input | 1 | Acknowledge strobe |
| ackLine | input | 3 | Line being acknowledged |
| intReq | output | 1 | Interrupt request to processor |
| intVector | output | 8 | Vector for the winning line |

## Verification
The bench drives single edges, held-high edges and level inputs to separate edge capture from level tracking. It drives pairs of simultaneous requests under different bases to show that rank, not line number, decides the winner. In-service stacks of two lines under a rotated base separate the non-specific, specific and rotating end-of-interrupt commands. Auto-EOI, poll with and without a pending line, special masking and nested mode are each set up so that the mode flips whether `intReq` rises.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINE_W    = 3;
  localparam int NUM_LINES = 1 << LINE_W;
  localparam int DATA_W    = 8;

  // Strobes and mode levels from control to datapath
  typedef struct packed {
    logic              initReset;
    logic              loadMask;
    logic [DATA_W-1:0] maskVal;
    logic              eoiHighest;
    logic              eoiRotate;
    logic              eoiSpecific;
    logic              specRotate;
    logic [LINE_W-1:0] specLine;
    logic              setBase;
    logic [LINE_W-1:0] baseVal;
    logic              pollTake;
    logic              autoEoi;
    logic              rotAutoEoi;
    logic              nested;
    logic              specialMask;
  } pic_ctrl_t;
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [NUM_LINES-1:0] reqMask,
  input  logic [LINE_W-1:0]    base,
  output logic                 found,
  output logic [LINE_W-1:0]    line
);
  // Scan from lowest rank last so it wins
  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqMask[base + LINE_W'(i)]) begin
        found = 1'b1;
        line  = base + LINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output pic_ctrl_t         stb,
  output logic [DATA_W-1:0] vectorBase,
  output logic              initBusy,
  output logic              readIsr,
  output logic              pollPend
);
  typedef enum logic [1:0] {CFG_IDLE, CFG_BASE, CFG_SKIP, CFG_MODE} cfg_e;

  cfg_e       cfgState;
  logic       needMode, autoEoiQ, rotAutoQ, nestedQ, specMaskQ;
  logic       wrLow, wrHigh, isInit, isCtl, isCmd;
  logic [2:0] cmd;

  assign wrLow  = wrEn && !addr;
  assign wrHigh = wrEn && addr;
  assign isInit = wrLow && wrData[4];
  assign isCtl  = wrLow && !wrData[4] && wrData[3];
  assign isCmd  = wrLow && !wrData[4] && !wrData[3];
  assign cmd    = wrData[7:5];
  assign initBusy = (cfgState != CFG_IDLE);

  always_comb begin
    stb             = '0;
    stb.initReset   = isInit;
    stb.loadMask    = wrHigh && (cfgState == CFG_IDLE);
    stb.maskVal     = wrData;
    stb.eoiHighest  = isCmd && (cmd[1:0] == 2'b01);
    stb.eoiRotate   = cmd[2];
    stb.eoiSpecific = isCmd && (cmd[1:0] == 2'b11);
    stb.specRotate  = isCmd && (cmd == 3'd7);
    stb.specLine    = wrData[LINE_W-1:0];
    stb.setBase     = isCmd && (cmd == 3'd6);
    stb.baseVal     = wrData[LINE_W-1:0] + LINE_W'(1);
    stb.pollTake    = rdEn && pollPend;
    stb.autoEoi     = autoEoiQ;
    stb.rotAutoEoi  = rotAutoQ;
    stb.nested      = nestedQ;
    stb.specialMask = specMaskQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgState   <= CFG_IDLE;
      needMode   <= 1'b0;
      vectorBase <= '0;
      autoEoiQ   <= 1'b0;
      rotAutoQ   <= 1'b0;
      nestedQ    <= 1'b0;
      specMaskQ  <= 1'b0;
      readIsr    <= 1'b0;
      pollPend   <= 1'b0;
    end else if (isInit) begin
      cfgState   <= CFG_BASE;
      needMode   <= wrData[0];
      vectorBase <= '0;
      autoEoiQ   <= 1'b0;
      rotAutoQ   <= 1'b0;
      nestedQ    <= 1'b0;
      specMaskQ  <= 1'b0;
      readIsr    <= 1'b0;
      pollPend   <= 1'b0;
    end else begin
      if (stb.pollTake) pollPend <= 1'b0;
      if (wrHigh) begin
        unique case (cfgState)
          CFG_BASE: begin
            vectorBase <= wrData & ~DATA_W'((1 << LINE_W) - 1);
            cfgState   <= CFG_SKIP;
          end
          CFG_SKIP: cfgState <= needMode ? CFG_MODE : CFG_IDLE;
          CFG_MODE: begin
            nestedQ  <= wrData[4];
            autoEoiQ <= wrData[1];
            cfgState <= CFG_IDLE;
          end
          default: ;
        endcase
      end
      if (isCtl) begin
        if (wrData[2]) pollPend  <= 1'b1;
        if (wrData[1]) readIsr   <= wrData[0];
        if (wrData[6]) specMaskQ <= wrData[5];
      end
      if (isCmd && cmd[1:0] == 2'b00) rotAutoQ <= cmd[2];
    end
  end

  AST_MASK_BLOCKED_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wrHigh && initBusy) |-> !stb.loadMask);  // R4
  AST_POLL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && pollPend && !wrEn) |=> !pollPend);  // R12
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pic_ctrl_t            stb,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] levelSel,
  input  logic                 ackValid,
  input  logic [LINE_W-1:0]    ackLine,
  output logic [NUM_LINES-1:0] irrQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] imrQ,
  output logic                 grantValid,
  output logic [LINE_W-1:0]    grantLine
);
  logic [NUM_LINES-1:0] lastQ, curMask, ackBit, grantBit, specBit, topBit;
  logic [NUM_LINES-1:0] edgeClr, isrClr, isrSet, edgeNext, irrNext, isrNext;
  logic [LINE_W-1:0]    baseQ, baseNext, reqLine, curLine, topLine, reqRank, curRank;
  logic                 reqFound, curFound, topFound;

  // Blocking set seen by the grant decision
  always_comb begin
    curMask = isrQ;
    if (stb.nested)      curMask[CASCADE_LINE] = 1'b0;
    if (stb.specialMask) curMask = curMask & ~imrQ;
  end

  pic_resolver u_req (.reqMask(irrQ & ~imrQ), .base(baseQ), .found(reqFound), .line(reqLine));
  pic_resolver u_cur (.reqMask(curMask),      .base(baseQ), .found(curFound), .line(curLine));
  pic_resolver u_top (.reqMask(isrQ),         .base(baseQ), .found(topFound), .line(topLine));

  assign reqRank    = reqLine - baseQ;
  assign curRank    = curLine - baseQ;
  assign grantValid = reqFound && (!curFound || reqRank < curRank);
  assign grantLine  = reqLine;

  assign ackBit   = NUM_LINES'(1) << ackLine;
  assign grantBit = NUM_LINES'(1) << grantLine;
  assign specBit  = NUM_LINES'(1) << stb.specLine;
  assign topBit   = NUM_LINES'(1) << topLine;

  always_comb begin
    edgeClr = '0;
    if (ackValid && !levelSel[ackLine]) edgeClr |= ackBit;
    if (stb.pollTake && grantValid)     edgeClr |= grantBit;
    edgeNext = (irrQ & ~edgeClr) | (irqIn & ~lastQ);
    irrNext  = (levelSel & irqIn) | (~levelSel & edgeNext);

    isrClr = '0;
    if (stb.eoiHighest && topFound)  isrClr |= topBit;
    if (stb.eoiSpecific)             isrClr |= specBit;
    if (stb.pollTake && grantValid)  isrClr |= grantBit;
    isrSet  = (ackValid && !stb.autoEoi) ? ackBit : '0;
    isrNext = (isrQ & ~isrClr) | isrSet;

    baseNext = baseQ;
    if (stb.eoiHighest && stb.eoiRotate && topFound) baseNext = topLine + LINE_W'(1);
    else if (stb.specRotate)                         baseNext = stb.specLine + LINE_W'(1);
    else if (stb.setBase)                            baseNext = stb.baseVal;
    else if (ackValid && stb.autoEoi && stb.rotAutoEoi) baseNext = ackLine + LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irrQ <= '0; isrQ <= '0; imrQ <= '0; lastQ <= '0; baseQ <= '0;
    end else if (stb.initReset) begin
      irrQ <= '0; isrQ <= '0; imrQ <= '0; lastQ <= '0; baseQ <= '0;
    end else begin
      irrQ  <= irrNext;
      isrQ  <= isrNext;
      lastQ <= irqIn;
      baseQ <= baseNext;
      if (stb.loadMask) imrQ <= stb.maskVal;
    end
  end

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(stb.initReset)) |->
      ((irrQ & $past(levelSel)) == ($past(irqIn) & $past(levelSel))));  // R3
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> (irrQ[grantLine] && !imrQ[grantLine]));  // R5
  AST_AUTO_EOI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && stb.autoEoi && !stb.initReset) |=> ($countones(isrQ) <= $countones($past(isrQ))));  // R8
  AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.eoiSpecific && !ackValid) |=> !isrQ[$past(stb.specLine)]);  // R10
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] levelSel,
  input  logic                 ackValid,
  input  logic [LINE_W-1:0]    ackLine,
  output logic                 intReq,
  output logic [DATA_W-1:0]    intVector
);
  pic_ctrl_t            stb;
  logic [DATA_W-1:0]    vectorBase;
  logic                 initBusy, readIsr, pollPend, grantValid;
  logic [NUM_LINES-1:0] irrQ, isrQ, imrQ;
  logic [LINE_W-1:0]    grantLine;

  pic_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .stb(stb), .vectorBase(vectorBase), .initBusy(initBusy), .readIsr(readIsr),
    .pollPend(pollPend)
  );

  pic_datapath #(.CASCADE_LINE(CASCADE_LINE)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .irqIn(irqIn), .levelSel(levelSel),
    .ackValid(ackValid), .ackLine(ackLine), .irrQ(irrQ), .isrQ(isrQ), .imrQ(imrQ),
    .grantValid(grantValid), .grantLine(grantLine)
  );

  always_comb begin
    if (pollPend)  rdData = grantValid ? DATA_W'(grantLine) : DATA_W'(7);
    else if (addr) rdData = imrQ;
    else           rdData = readIsr ? isrQ : irrQ;
  end

  assign intReq    = grantValid && !initBusy;
  assign intVector = vectorBase | DATA_W'(grantLine);
endmodule

// File: tb/pic_core_tb.sv
`timescale 1ns/1ps
module pic_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0, ackValid = 1'b0;
  logic [7:0] wrData = '0, irqIn = '0, levelSel = '0;
  logic [2:0] ackLine = '0;
  logic [7:0] rdData, intVector;
  logic       intReq;
  int         nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  pic_core u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .levelSel(levelSel), .ackValid(ackValid),
    .ackLine(ackLine), .intReq(intReq), .intVector(intVector)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    ackValid = 1'b1; ackLine = l;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic drive(input logic [7:0] v);
    irqIn = v;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] base, input logic useMode, input logic [7:0] mode);
    wr(1'b0, 8'h10 | {7'b0, useMode});
    wr(1'b1, base);
    wr(1'b1, 8'hAA);
    if (useMode) wr(1'b1, mode);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, d); chk("R1 pending after reset", d, 8'h00);
    rd(1'b1, d); chk("R1 mask after reset", d, 8'h00);
    chk("R1 intReq after reset", {7'b0, intReq}, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] d;
    drive(8'h00);
    wr(1'b0, 8'h11);
    drive(8'h08);
    chk("R4 intReq held low during config", {7'b0, intReq}, 8'h00);
    wr(1'b1, 8'h47); wr(1'b1, 8'hAA); wr(1'b1, 8'h00);
    rd(1'b1, d); chk("R4 config words do not load mask", d, 8'h00);
    chk("R4 intReq after config", {7'b0, intReq}, 8'h01);
    chk("R14 vector base|line", intVector, 8'h43);
    ack(3'd3);
    rd(1'b0, d); chk("R7 edge pending cleared by ack", d, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R11 in-service readback", d, 8'h08);
    chk("R7 no request while serviced", {7'b0, intReq}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 non-specific EOI clears", d, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    drive(8'h00); cfg(8'h20, 1'b0, 8'h00);
    drive(8'h08); ack(3'd3);
    rd(1'b0, d); chk("R2 held high does not re-set", d, 8'h00);
    drive(8'h00); drive(8'h08);
    rd(1'b0, d); chk("R2 new rising edge sets", d, 8'h08);
  endtask

  task automatic t_level();
    logic [7:0] d;
    drive(8'h00); levelSel = 8'h20; cfg(8'h00, 1'b0, 8'h00);
    drive(8'h20);
    rd(1'b0, d); chk("R3 level sets pending", d, 8'h20);
    ack(3'd5);
    rd(1'b0, d); chk("R3 ack keeps level pending", d, 8'h20);
    drive(8'h00);
    rd(1'b0, d); chk("R3 pending follows low input", d, 8'h00);
    levelSel = 8'h00;
  endtask

  task automatic t_mask();
    logic [7:0] d;
    drive(8'h00); cfg(8'h00, 1'b0, 8'h00);
    wr(1'b1, 8'h08);
    rd(1'b1, d); chk("R5 mask readback", d, 8'h08);
    drive(8'h08);
    chk("R5 masked line silent", {7'b0, intReq}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R5 unmasked line requests", {7'b0, intReq}, 8'h01);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    drive(8'h00); cfg(8'h00, 1'b0, 8'h00);
    drive(8'h42);
    chk("R6 lowest line wins at base 0", intVector, 8'h01);
    wr(1'b0, 8'hC5);
    chk("R10 set-priority moves base to 6", intVector, 8'h06);
    ack(3'd6);
    chk("R6 lower rank blocked by service", {7'b0, intReq}, 8'h00);
    wr(1'b0, 8'hE6);
    chk("R10 specific rotate releases", {intVector[6:0], intReq}, {7'h01, 1'b1});
    ack(3'd1);
    wr(1'b0, 8'h40);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R10 command 2 changes nothing", d, 8'h02);
    wr(1'b0, 8'h61);
    rd(1'b0, d); chk("R10 specific EOI clears line 1", d, 8'h00);
  endtask

  task automatic t_rot_eoi();
    drive(8'h00); cfg(8'h00, 1'b0, 8'h00);
    drive(8'h04); ack(3'd2);
    drive(8'h05);
    chk("R6 higher rank preempts", intVector, 8'h00);
    ack(3'd0);
    wr(1'b0, 8'hA0);
    drive(8'h04); drive(8'h0D);
    chk("R9 rotate EOI base 1 blocks", {7'b0, intReq}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R9 EOI then line 3 wins", {intVector[6:0], intReq}, {7'h03, 1'b1});
  endtask

  task automatic t_auto();
    logic [7:0] d;
    drive(8'h00); cfg(8'h00, 1'b1, 8'h02);
    wr(1'b0, 8'h80);
    drive(8'h10); ack(3'd4);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R8 auto-EOI leaves service empty", d, 8'h00);
    drive(8'h00); drive(8'h90);
    chk("R8 auto rotation base 5", intVector, 8'h07);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    drive(8'h00); cfg(8'h00, 1'b0, 8'h00);
    drive(8'h20);
    wr(1'b0, 8'h0C);
    rd(1'b0, d); chk("R12 poll returns line", d, 8'h05);
    rd(1'b0, d); chk("R12 poll consumed pending", d, 8'h00);
    wr(1'b0, 8'h0C);
    rd(1'b0, d); chk("R12 empty poll", d, 8'h07);
  endtask

  task automatic t_special();
    drive(8'h00); cfg(8'h00, 1'b0, 8'h00);
    drive(8'h02); ack(3'd1);
    drive(8'h12);
    chk("R13 service blocks lower line", {7'b0, intReq}, 8'h00);
    wr(1'b1, 8'h02);
    chk("R13 mask alone still blocks", {7'b0, intReq}, 8'h00);
    wr(1'b0, 8'h68);
    chk("R13 special mask unblocks", {intVector[6:0], intReq}, {7'h04, 1'b1});
  endtask

  task automatic t_nested();
    drive(8'h00); cfg(8'h00, 1'b1, 8'h10);
    drive(8'h04); ack(3'd2);
    drive(8'h00); drive(8'h04);
    chk("R13 nested cascade re-request", {intVector[6:0], intReq}, {7'h02, 1'b1});
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_edge();
    t_level();
    t_mask();
    t_prio();
    t_rot_eoi();
    t_auto();
    t_poll();
    t_special();
    t_nested();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule